// File: doc/BRIEF.md
# Chained DAC Load Sequencer

This block runs from the system clock and acts as the serial master for a string of daisy-chained 12-bit DACs. A client places one 12-bit code per channel on a parallel bus and pulses `start`. The block then pulls the frame line low and shifts out one 16-bit word per channel, farthest channel first, so that each word has rippled into its own device when the frame ends. It raises the frame line, waits one serial-clock period, and drops the load strobe for a fixed number of system clocks so that every channel updates at the same moment.

The serial clock idles low. Data moves on its rising edge and is taken by the DACs on its falling edge. The half period, the number of channels and the strobe width are parameters. A second variant, chosen by parameter, sends each word as two 8-clock bursts with an idle gap between them and the frame line held low through the gap, as a byte-oriented host would.

The state machine has eight states. `ST_IDLE` goes to `ST_LEAD` on start. `ST_LEAD` (frame low, clock low) goes to `ST_HIGH`. `ST_HIGH` (clock high) goes to `ST_LOW` on the falling edge. `ST_LOW` goes to `ST_HIGH` for the next bit, or to `ST_GAP` after a byte boundary in byte mode, or to `ST_SETTLE` after the last bit. `ST_GAP` goes to `ST_HIGH`. `ST_SETTLE` (frame high) goes to `ST_STROBE` (load low). `ST_STROBE` goes to `ST_DONE`, which returns to `ST_IDLE`.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, `sync_n`=1, `ldac_n`=1, `sclk`=0, `busy`=0 and `done`=0.
- R2: Each load produces exactly 16×N_DAC falling edges of `sclk` while `sync_n` is low. `sclk` is never high while `sync_n` is high.
- R3: Within a frame, `sdin` changes only in the same system cycle in which `sclk` rises. It is stable while `sclk` stays high and across each falling edge.
- R4: Each 16-bit word is four leading bits driven 0, followed by the 12-bit code, MSB first and LSB last.
- R5: Channel i takes `codes[i*12+11 : i*12]`, with channel 0 nearest the master. The word for channel N_DAC-1 is sent first and the word for channel 0 last.
- R6: Each `sclk` half period lasts HALF_CLKS system clocks. `sync_n` falls HALF_CLKS clocks before the first rising edge and rises HALF_CLKS clocks after the last falling edge. In word mode `sync_n` is therefore low for HALF_CLKS×(1+32×N_DAC) clocks.
- R7: With BYTE_MODE=1, after every 8th falling edge except the last, `sclk` stays low for GAP_CLKS extra clocks while `sync_n` stays low. This gives 2×N_DAC−1 gaps and adds (2×N_DAC−1)×GAP_CLKS clocks to the low time of `sync_n`. With BYTE_MODE=0 there are no gaps.
- R8: After `sync_n` rises, it stays high with `ldac_n` high for 2×HALF_CLKS clocks. `ldac_n` then goes low for exactly LDAC_CLKS clocks, and only while `sync_n` is high. Elaboration fails unless LDAC_CLKS×CLK_NS ≥ 50.
- R9: `done` is high for exactly one cycle per load, the first cycle with `ldac_n` high again. `busy` is high from the cycle after `start` is taken through the `done` cycle, and low after it.
- R10: A `start` pulse while `busy` is high has no effect. The frame in progress is neither restarted nor altered, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to load all channels |
| codes | input | N_DAC×12 | Channel codes; channel i in bits i*12+11..i*12 |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | One-cycle pulse at end of sequence |
| sclk | output | 1 | Serial clock, idle low |
| sdin | output | 1 | Serial data, valid at falling `sclk` |
| sync_n | output | 1 | Frame line, low during shifting |
| ldac_n | output | 1 | Active-low simultaneous update strobe |

## Verification
The checker assumes that `start` is a synchronous single-cycle pulse. It also assumes that `codes` is stable in the cycle in which `start` is taken, since that is the only cycle in which the bus is latched. The bench drives `start` and `codes` on the falling system clock edge. It changes `codes` only while idle, except in the scenario that deliberately disturbs the bus and re-pulses `start` mid-frame to show that nothing is taken. Serial outputs are judged from the falling-edge samples of `sclk` and from run lengths counted in system clocks.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_SETTLE,
        ST_STROBE,
        ST_DONE
    } dcl_state_e;
endpackage

// File: rtl/dcl_timer.sv
// Down-counting phase timer: a load of length L keeps expired low for L-1 cycles.
module dcl_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= len - W'(1);
        else if (cnt != '0)    cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dcl_frame_reg.sv
// Holds the whole chain frame; the farthest channel occupies the top word.
module dcl_frame_reg #(
    parameter int N_DAC  = 4,
    parameter int CODE_W = 12,
    parameter int WORD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    shift,
    input  logic [N_DAC*CODE_W-1:0] codes,
    output logic                    sdin
);
    localparam int TOTAL = N_DAC * WORD_W;
    localparam int PAD   = WORD_W - CODE_W;

    logic [TOTAL-1:0] frame_in;
    logic [TOTAL-1:0] sreg;

    for (genvar g = 0; g < N_DAC; g++) begin : g_word
        assign frame_in[g*WORD_W +: WORD_W] = {{PAD{1'b0}}, codes[g*CODE_W +: CODE_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sreg <= '0;
        else if (load)   sreg <= frame_in;
        else if (shift)  sreg <= {sreg[TOTAL-2:0], 1'b0};
    end

    assign sdin = sreg[TOTAL-1];
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
    import dcl_pkg::*;
#(
    parameter int N_DAC     = 4,
    parameter int CODE_W    = 12,
    parameter int WORD_W    = 16,
    parameter int HALF_CLKS = 4,
    parameter int GAP_CLKS  = 3,
    parameter int LDAC_CLKS = 4,
    parameter int CLK_NS    = 20,
    parameter bit BYTE_MODE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_DAC*CODE_W-1:0] codes,
    output logic                    busy,
    output logic                    done,
    output logic                    sclk,
    output logic                    sdin,
    output logic                    sync_n,
    output logic                    ldac_n
);
    localparam int TOTAL = N_DAC * WORD_W;
    localparam int BW    = $clog2(TOTAL + 1);
    localparam int M1    = (2 * HALF_CLKS > GAP_CLKS) ? 2 * HALF_CLKS : GAP_CLKS;
    localparam int MAXL  = (M1 > LDAC_CLKS) ? M1 : LDAC_CLKS;
    localparam int TW    = $clog2(MAXL + 1);

    if (LDAC_CLKS * CLK_NS < 50) begin : g_ldac_short
        $error("update strobe shorter than 50 ns");
    end
    if (WORD_W <= CODE_W || HALF_CLKS < 1 || GAP_CLKS < 1 || LDAC_CLKS < 1) begin : g_bad_cfg
        $error("illegal sequencer configuration");
    end

    dcl_state_e    state, nxt;
    logic          tmr_load, tmr_exp, f_load, f_shift, fall_ev;
    logic [TW-1:0] tmr_len;
    logic [BW-1:0] bits;

    dcl_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
    );

    dcl_frame_reg #(.N_DAC(N_DAC), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .load(f_load), .shift(f_shift), .codes(codes), .sdin(sdin)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Falling-edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bits <= '0;
        else if (f_load)  bits <= '0;
        else if (fall_ev) bits <= bits + BW'(1);
    end

    // Transitions
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_len  = TW'(HALF_CLKS);
        f_load   = 1'b0;
        f_shift  = 1'b0;
        fall_ev  = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                nxt = ST_LEAD; tmr_load = 1'b1; f_load = 1'b1;
            end
            ST_LEAD: if (tmr_exp) begin
                nxt = ST_HIGH; tmr_load = 1'b1;
            end
            ST_HIGH: if (tmr_exp) begin
                nxt = ST_LOW; tmr_load = 1'b1; fall_ev = 1'b1;
            end
            ST_LOW: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (bits == BW'(TOTAL)) begin
                    nxt = ST_SETTLE; tmr_len = TW'(2 * HALF_CLKS);
                end else if (BYTE_MODE && bits[2:0] == 3'd0) begin
                    nxt = ST_GAP; tmr_len = TW'(GAP_CLKS);
                end else begin
                    nxt = ST_HIGH; f_shift = 1'b1;
                end
            end
            ST_GAP: if (tmr_exp) begin
                nxt = ST_HIGH; tmr_load = 1'b1; f_shift = 1'b1;
            end
            ST_SETTLE: if (tmr_exp) begin
                nxt = ST_STROBE; tmr_load = 1'b1; tmr_len = TW'(LDAC_CLKS);
            end
            ST_STROBE: if (tmr_exp) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sclk   = (state == ST_HIGH);
        sync_n = !(state inside {ST_LEAD, ST_HIGH, ST_LOW, ST_GAP});
        ldac_n = (state != ST_STROBE);
        busy   = (state != ST_IDLE);
        done   = (state == ST_DONE);
    end
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sdin,
    input logic sync_n,
    input logic ldac_n
);
    // R2
    sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sync_n);

    // R3
    sdin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdin));

    // R8
    ldac_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |-> sync_n);

    // R8
    ldac_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ldac_n) |-> $past(sync_n));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ldac_n && !$past(ldac_n));

    // R10
    frame_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> !$past(busy));
endmodule

bind dac_chain_loader dcl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sclk(sclk), .sdin(sdin), .sync_n(sync_n), .ldac_n(ldac_n)
);

// File: tb/tb_dac_chain_loader.sv
module tb_dac_chain_loader;
    localparam int N     = 4;
    localparam int HALF  = 4;
    localparam int GAP   = 3;
    localparam int LDW   = 4;
    localparam int TOTAL = N * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0;
    logic [N*12-1:0] codes_a = '0, codes_b = '0;
    logic a_busy, a_done, a_sclk, a_sdin, a_sync, a_ldac;
    logic b_busy, b_done, b_sclk, b_sdin, b_sync, b_ldac;

    always #10 clk = ~clk;

    dac_chain_loader #(.N_DAC(N), .HALF_CLKS(HALF), .GAP_CLKS(GAP), .LDAC_CLKS(LDW),
                       .CLK_NS(20), .BYTE_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start_a), .codes(codes_a), .busy(a_busy),
        .done(a_done), .sclk(a_sclk), .sdin(a_sdin), .sync_n(a_sync), .ldac_n(a_ldac));

    dac_chain_loader #(.N_DAC(N), .HALF_CLKS(HALF), .GAP_CLKS(GAP), .LDAC_CLKS(LDW),
                       .CLK_NS(20), .BYTE_MODE(1'b1)) dut_byte (
        .clk(clk), .rst_n(rst_n), .start(start_b), .codes(codes_b), .busy(b_busy),
        .done(b_done), .sclk(b_sclk), .sdin(b_sdin), .sync_n(b_sync), .ldac_n(b_ldac));

    logic sel = 1'b0;
    logic m_busy, m_done, m_sclk, m_sdin, m_sync, m_ldac;
    assign m_busy = sel ? b_busy : a_busy;
    assign m_done = sel ? b_done : a_done;
    assign m_sclk = sel ? b_sclk : a_sclk;
    assign m_sdin = sel ? b_sdin : a_sdin;
    assign m_sync = sel ? b_sync : a_sync;
    assign m_ldac = sel ? b_ldac : a_ldac;

    int checks = 0, failures = 0, cycles = 0;
    int falls, synclow, ldaclow, settle, dones, sdin_bad, sclk_bad, long_lows, lowrun, sync_falls;
    bit settling;
    logic prev_sclk, prev_sdin, prev_sync;
    bit cap [TOTAL];

    always @(negedge clk) begin
        if (!m_sync) synclow++;
        if (!m_ldac) begin ldaclow++; settling = 0; end
        if (m_sync && !prev_sync) settling = 1;
        if (settling && m_sync && m_ldac) settle++;
        if (prev_sclk && !m_sclk && !m_sync) begin
            if (falls < TOTAL) cap[falls] = m_sdin;
            falls++;
        end
        if (!prev_sync && !m_sync && (m_sdin !== prev_sdin) && !(!prev_sclk && m_sclk)) sdin_bad++;
        if (m_sclk && m_sync) sclk_bad++;
        if (!m_sync && !m_sclk) lowrun++;
        else begin
            if (lowrun > HALF) long_lows++;
            lowrun = 0;
        end
        if (m_done) dones++;
        if (prev_sync && !m_sync) sync_falls++;
        prev_sclk = m_sclk; prev_sdin = m_sdin; prev_sync = m_sync;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        falls = 0; synclow = 0; ldaclow = 0; settle = 0; dones = 0; sdin_bad = 0;
        sclk_bad = 0; long_lows = 0; lowrun = 0; sync_falls = 0; settling = 0;
    endtask

    task automatic pulse_start(input bit s);
        if (s) start_b = 1'b1; else start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
    endtask

    // Runs one load on the selected instance and checks every timing and data rule.
    task automatic run_load(input bit s, input logic [N*12-1:0] c, input bit disturb);
        int mism, pad_bad, first_word;
        sel = s;
        @(negedge clk);
        clear_mon();
        if (s) codes_b = c; else codes_a = c;
        pulse_start(s);
        chk(m_busy === 1'b1, "R9 busy after start", int'(m_busy), 1);
        if (disturb) begin
            repeat (100) @(negedge clk);
            if (s) codes_b = ~c; else codes_a = ~c;
            pulse_start(s);
            repeat (40) @(negedge clk);
            pulse_start(s);
        end
        while (dones == 0) @(negedge clk);
        chk(m_busy === 1'b0, "R9 busy after done", int'(m_busy), 0);
        repeat (20) @(negedge clk);
        mism = 0; pad_bad = 0; first_word = 0;
        for (int k = 0; k < TOTAL; k++) begin
            int ch, b;
            bit e;
            ch = N - 1 - k / 16;
            b  = k % 16;
            e  = (b < 4) ? 1'b0 : c[ch*12 + 11 - (b - 4)];
            if (b < 4 && cap[k]) pad_bad++;
            if (cap[k] != e) mism++;
            if (k >= 4 && k < 16) first_word = (first_word << 1) | int'(cap[k]);
        end
        chk(falls == TOTAL, "R2 falling edges", falls, TOTAL);
        chk(sclk_bad == 0, "R2 sclk outside frame", sclk_bad, 0);
        chk(sdin_bad == 0, "R3 data change off rising edge", sdin_bad, 0);
        chk(pad_bad == 0 && mism == 0, "R4 word bits", mism, 0);
        chk(first_word == int'(c[N*12-1 -: 12]), "R5 first word is far channel",
            first_word, int'(c[N*12-1 -: 12]));
        if (s) begin
            chk(long_lows == 2*N-1, "R7 byte gaps", long_lows, 2*N-1);
            chk(synclow == HALF*(1+32*N) + (2*N-1)*GAP, "R7 sync low length",
                synclow, HALF*(1+32*N) + (2*N-1)*GAP);
        end else begin
            chk(long_lows == 0, "R7 no gaps in word mode", long_lows, 0);
            chk(synclow == HALF*(1+32*N), "R6 sync low length", synclow, HALF*(1+32*N));
        end
        chk(settle == 2*HALF, "R8 settle before strobe", settle, 2*HALF);
        chk(ldaclow == LDW, "R8 strobe width", ldaclow, LDW);
        chk(dones == 1, "R9 done pulses", dones, 1);
        if (disturb)
            chk(sync_falls == 1, "R10 start while busy ignored", sync_falls, 1);
    endtask

    task automatic test_reset();
        chk(a_sync === 1'b1 && a_ldac === 1'b1 && a_sclk === 1'b0, "R1 line idle",
            int'({a_sync, a_ldac, a_sclk}), 3'b110);
        chk(a_busy === 1'b0 && a_done === 1'b0, "R1 status idle", int'({a_busy, a_done}), 0);
        chk(b_sync === 1'b1 && b_ldac === 1'b1 && b_sclk === 1'b0, "R1 byte instance idle",
            int'({b_sync, b_ldac, b_sclk}), 3'b110);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_mon();
        prev_sclk = 1'b0; prev_sdin = 1'b0; prev_sync = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_load(1'b0, {12'hABC, 12'h123, 12'h456, 12'h789}, 1'b0);
        run_load(1'b0, {12'hFFF, 12'h000, 12'h801, 12'h7FE}, 1'b0);
        run_load(1'b1, {12'h5A5, 12'hC3C, 12'h0F1, 12'hE2D}, 1'b0);
        run_load(1'b0, {12'h111, 12'h222, 12'h333, 12'h444}, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule